// File: doc/BRIEF.md
# Pipelined Two-Operand Integer Datapath with Result Forwarding

This block is the execute back end of a small integer core. It accepts one 16-bit two-operand instruction per cycle and moves it through four one-cycle stages: capture, operand read, ALU, and write-back. The general register set is held twice, once for the destination-side operand and once for the source-side operand, so both operands of an instruction are read in the same cycle. Every write-back updates both copies on the same edge.

A result that is still in flight can be needed by a later instruction. The operand selectors take it straight from the ALU output or from the result register instead of the stale file entry, so a dependent instruction can follow its producer on the next cycle without a bubble. There are no condition codes and no status state. Each write-back is shown on the result port (valid, register index, value), which is how a surrounding core, or a bench, observes retired results.

Top module: `fwd_pipe_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wb_valid` is low; after reset every general register reads as zero.
- R2: `in_instr` holds the opcode in bits 15:8, the destination/first-operand index Rx in bits 7:4 and the second-operand index Ry in bits 3:0. An instruction sampled with `in_valid` high at clock edge N shows its result on `wb_valid`/`wb_reg`/`wb_data` after edge N+2, with `wb_reg` equal to Rx, and the result replaces register Rx.
- R3: Register-form opcodes compute Rx op Ry: 8'h00 add, 8'h01 subtract (Rx minus Ry), 8'h02 AND, 8'h03 OR, 8'h04 XOR, 8'h05 move (Rx takes Ry).
- R4: Immediate-form opcodes 8'h08 to 8'h0D perform the same six operations in the same order, with the Ry field value zero-extended to 32 bits used as the second operand in place of a register.
- R5: An opcode outside the two sets above, or a cycle with `in_valid` low, produces no write-back and changes no register.
- R6: An instruction reading a register written by the instruction directly ahead of it receives the new value with no stall, so results retire one per cycle.
- R7: An instruction reading a register written by the instruction two places ahead receives the new value from the result register.
- R8: Both operands may be forwarded in the same cycle, including when Rx and Ry name the same register.
- R9: When the instructions one and two places ahead both write the register being read, the operand takes the value of the one directly ahead.
- R10: Both register copies hold the same contents at all times, so a register read later through the Rx field or the Ry field returns the same written value.
- R11: Add and subtract wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_instr | input | 16 | Opcode, Rx index, Ry index |
| wb_valid | output | 1 | A result is being written back this cycle |
| wb_reg | output | 4 | Register index being written |
| wb_data | output | 32 | Value being written |

## Verification
On every cycle the checker confirms that the two register copies agree whenever both read ports address the same register. It confirms that an operand matched against the instruction directly ahead lands as that instruction's ALU result and that one matched only against the instruction two ahead lands as the result register's value. It also confirms that an illegal slot never reaches write-back and that write-back only follows a valid ALU stage. What only the scenarios show is that results are arithmetically right for each opcode and immediate, that the youngest producer wins when two are in flight, that a no-op leaves the register contents untouched, and that after dense dependent sequences the final register set matches an independent sequential model.

// File: rtl/fp_pkg.sv
package fp_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_XOR = 3'd4,
      ALU_MOV = 3'd5
   } alu_fn_e;

   typedef struct packed {
      logic    legal;
      logic    imm;
      alu_fn_e fn;
   } dec_t;

   localparam int OPCODE_BITS = 8;

   // Opcode groups: 0x00..0x05 register form, 0x08..0x0D immediate form.
   function automatic dec_t decode_op(input logic [OPCODE_BITS-1:0] opc);
      dec_t d;
      d.imm   = opc[3];
      d.fn    = alu_fn_e'(opc[2:0]);
      d.legal = (opc[7:4] == 4'h0) && (opc[2:0] <= 3'd5);
      return d;
   endfunction

endpackage

// File: rtl/fp_regbank.sv
module fp_regbank #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 16,
   localparam int IDX_W  = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [REG_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_CNT; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/fp_opsel.sv
module fp_opsel #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] file_q,
   input  logic              near_en,
   input  logic [IDX_W-1:0]  near_idx,
   input  logic [DATA_W-1:0] near_val,
   input  logic              far_en,
   input  logic [IDX_W-1:0]  far_idx,
   input  logic [DATA_W-1:0] far_val,
   output logic [DATA_W-1:0] opnd
);

   logic near_hit, far_hit;

   assign near_hit = near_en && (near_idx == addr);
   assign far_hit  = far_en  && (far_idx  == addr);

   // Youngest producer first, then the older one, then the file.
   always_comb begin
      if (near_hit)     opnd = near_val;
      else if (far_hit) opnd = far_val;
      else              opnd = file_q;
   end

endmodule

// File: rtl/fp_alu.sv
module fp_alu #(
   parameter int DATA_W = 32
) (
   input  fp_pkg::alu_fn_e   fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (fn)
         fp_pkg::ALU_ADD: y = a + b;
         fp_pkg::ALU_SUB: y = a - b;
         fp_pkg::ALU_AND: y = a & b;
         fp_pkg::ALU_OR:  y = a | b;
         fp_pkg::ALU_XOR: y = a ^ b;
         default:         y = b;
      endcase
   end

endmodule

// File: rtl/fwd_pipe_core.sv
module fwd_pipe_core #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 16,
   parameter int OPC_W   = 8,
   localparam int IDX_W   = $clog2(REG_CNT),
   localparam int INSTR_W = OPC_W + 2*IDX_W,
   localparam int N_PORTS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   output logic               wb_valid,
   output logic [IDX_W-1:0]   wb_reg,
   output logic [DATA_W-1:0]  wb_data
);
   import fp_pkg::*;

   if (OPC_W != OPCODE_BITS) begin : g_bad_opc
      $error("fwd_pipe_core: OPC_W must equal the package opcode width");
   end
   if (REG_CNT != (1 << IDX_W)) begin : g_bad_cnt
      $error("fwd_pipe_core: REG_CNT must be a power of two");
   end
   if (DATA_W <= IDX_W) begin : g_bad_w
      $error("fwd_pipe_core: DATA_W must exceed the register index width");
   end

   // Stage 1: capture
   logic               f_vld;
   logic [INSTR_W-1:0] f_ins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_vld <= 1'b0;
         f_ins <= '0;
      end else begin
         f_vld <= in_valid;
         f_ins <= in_instr;
      end
   end

   logic [OPC_W-1:0] f_opc;
   logic [IDX_W-1:0] f_rx, f_ry;
   dec_t             f_dec;

   assign f_opc = f_ins[INSTR_W-1 -: OPC_W];
   assign f_rx  = f_ins[2*IDX_W-1 -: IDX_W];
   assign f_ry  = f_ins[IDX_W-1:0];
   assign f_dec = decode_op(f_opc);

   // Stage 2: operand read from the two copies, with forwarding
   logic               e_vld, e_wr;
   alu_fn_e            e_fn;
   logic [IDX_W-1:0]   e_rd;
   logic [DATA_W-1:0]  e_a, e_b;
   logic [DATA_W-1:0]  alu_y;

   logic [IDX_W-1:0]   rd_addr [N_PORTS];
   logic [DATA_W-1:0]  rd_raw  [N_PORTS];
   logic [DATA_W-1:0]  rd_fwd  [N_PORTS];

   assign rd_addr[0] = f_rx;
   assign rd_addr[1] = f_ry;

   for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      fp_regbank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wb_valid),
         .waddr (wb_reg),
         .wdata (wb_data),
         .raddr (rd_addr[g]),
         .rdata (rd_raw[g])
      );

      fp_opsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
         .addr     (rd_addr[g]),
         .file_q   (rd_raw[g]),
         .near_en  (e_wr),
         .near_idx (e_rd),
         .near_val (alu_y),
         .far_en   (wb_valid),
         .far_idx  (wb_reg),
         .far_val  (wb_data),
         .opnd     (rd_fwd[g])
      );
   end

   logic [DATA_W-1:0] imm_val, opnd_b;

   assign imm_val = {{(DATA_W-IDX_W){1'b0}}, f_ry};
   assign opnd_b  = f_dec.imm ? imm_val : rd_fwd[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld <= 1'b0;
         e_wr  <= 1'b0;
         e_fn  <= ALU_ADD;
         e_rd  <= '0;
         e_a   <= '0;
         e_b   <= '0;
      end else begin
         e_vld <= f_vld;
         e_wr  <= f_vld && f_dec.legal;
         e_fn  <= f_dec.fn;
         e_rd  <= f_rx;
         e_a   <= rd_fwd[0];
         e_b   <= opnd_b;
      end
   end

   // Stage 3: ALU into the result register
   fp_alu #(.DATA_W(DATA_W)) u_alu (
      .fn (e_fn),
      .a  (e_a),
      .b  (e_b),
      .y  (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_reg   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= e_wr;
         wb_reg   <= e_rd;
         wb_data  <= alu_y;
      end
   end

   // Stage 4: write-back into both copies happens in the banks above.

endmodule

// File: rtl/fp_core_chk.sv
module fp_core_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wb_valid,
   input logic [IDX_W-1:0]  wb_reg,
   input logic [DATA_W-1:0] wb_data,
   input logic              e_vld,
   input logic              e_wr,
   input logic [IDX_W-1:0]  e_rd,
   input logic [DATA_W-1:0] e_a,
   input logic [DATA_W-1:0] alu_y,
   input logic              f_vld,
   input logic [IDX_W-1:0]  f_rx,
   input logic [IDX_W-1:0]  f_ry,
   input logic [DATA_W-1:0] raw_x,
   input logic [DATA_W-1:0] raw_y
);

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !wb_valid);

   assert_wb_follows_alu_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(e_vld));

   assert_noop_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (e_vld && !e_wr) |=> !wb_valid);

   assert_near_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (f_vld && e_wr && e_rd == f_rx) |=> (e_a == $past(alu_y)));

   assert_far_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (f_vld && !(e_wr && e_rd == f_rx) && wb_valid && wb_reg == f_rx)
      |=> (e_a == $past(wb_data)));

   assert_copies_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (f_rx == f_ry) |-> (raw_x == raw_y));

endmodule

bind fwd_pipe_core fp_core_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wb_valid (wb_valid),
   .wb_reg   (wb_reg),
   .wb_data  (wb_data),
   .e_vld    (e_vld),
   .e_wr     (e_wr),
   .e_rd     (e_rd),
   .e_a      (e_a),
   .alu_y    (alu_y),
   .f_vld    (f_vld),
   .f_rx     (f_rx),
   .f_ry     (f_ry),
   .raw_x    (rd_raw[0]),
   .raw_y    (rd_raw[1])
);

// File: tb/sim_fwd_pipe_core.sv
module sim_fwd_pipe_core;

   localparam logic [7:0] ADD = 8'h00, SUB = 8'h01, AND = 8'h02, ORR = 8'h03,
                          XOR = 8'h04, MOV = 8'h05, ADDI = 8'h08, SUBI = 8'h09,
                          ANDI = 8'h0A, ORI = 8'h0B, XORI = 8'h0C, MOVI = 8'h0D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_instr = '0;
   logic        wb_valid;
   logic [3:0]  wb_reg;
   logic [31:0] wb_data;

   int checks = 0;
   int fails  = 0;

   logic [31:0] model [16];
   bit          dl_v [3];
   logic [3:0]  dl_r [3];
   logic [31:0] dl_d [3];
   string       dl_t [3];

   always #5 clk = ~clk;

   fwd_pipe_core u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_instr (in_instr),
      .wb_valid (wb_valid),
      .wb_reg   (wb_reg),
      .wb_data  (wb_data)
   );

   // One cycle: check the write-back due now, then present the next slot.
   task automatic step(input bit v, input logic [7:0] opc, input logic [3:0] rx,
                       input logic [3:0] ry, input string tag);
      bit          legal;
      logic [31:0] a, b, y;
      @(negedge clk);
      checks++;
      if (wb_valid !== dl_v[2] ||
          (dl_v[2] && (wb_reg !== dl_r[2] || wb_data !== dl_d[2]))) begin
         fails++;
         $display("FAIL %s: write-back v/reg/data = %0b/%0d/%h, expected %0b/%0d/%h",
                  dl_t[2], wb_valid, wb_reg, wb_data, dl_v[2], dl_r[2], dl_d[2]);
      end
      for (int k = 2; k > 0; k--) begin
         dl_v[k] = dl_v[k-1]; dl_r[k] = dl_r[k-1];
         dl_d[k] = dl_d[k-1]; dl_t[k] = dl_t[k-1];
      end
      legal = v && ((opc <= 8'h05) || (opc >= 8'h08 && opc <= 8'h0D));
      a = model[rx];
      b = (opc >= 8'h08) ? {28'h0, ry} : model[ry];
      case (opc & 8'h07)
         8'h00:   y = a + b;
         8'h01:   y = a - b;
         8'h02:   y = a & b;
         8'h03:   y = a | b;
         8'h04:   y = a ^ b;
         default: y = b;
      endcase
      if (legal) model[rx] = y;
      dl_v[0] = legal; dl_r[0] = rx; dl_d[0] = y; dl_t[0] = tag;
      in_valid = v;
      in_instr = {opc, rx, ry};
   endtask

   task automatic op(input logic [7:0] opc, input logic [3:0] rx, input logic [3:0] ry,
                     input string tag);
      step(1'b1, opc, rx, ry, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 4'h0, 4'h0, tag);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 16; i++) model[i] = '0;
      for (int i = 0; i < 3; i++) begin
         dl_v[i] = 1'b0; dl_r[i] = '0; dl_d[i] = '0; dl_t[i] = "R1";
      end
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (wb_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: wb_valid in reset = %0b, expected 0", wb_valid);
      end
      rst_n = 1'b1;
      // R1: every register reads zero after reset
      for (int r = 0; r < 16; r++) op(MOV, 4'(r), 4'(r), "R1");
      idle(3, "R1");
   endtask

   task automatic t_alu_ops;
      op(MOVI, 4'd1, 4'd12, "R4");
      op(MOVI, 4'd2, 4'd10, "R4");
      idle(2, "R3");
      op(MOV, 4'd3, 4'd1, "R3");
      op(MOV, 4'd4, 4'd1, "R3");
      op(MOV, 4'd5, 4'd1, "R3");
      op(MOV, 4'd6, 4'd1, "R3");
      op(MOV, 4'd7, 4'd1, "R3");
      idle(3, "R3");
      op(ADD, 4'd3, 4'd2, "R3");
      op(SUB, 4'd4, 4'd2, "R3");
      op(AND, 4'd5, 4'd2, "R3");
      op(ORR, 4'd6, 4'd2, "R3");
      op(XOR, 4'd7, 4'd2, "R3");
      idle(3, "R3");
   endtask

   task automatic t_imm;
      op(ADDI, 4'd8, 4'd15, "R4");
      op(SUBI, 4'd8, 4'd3, "R4");
      op(ORI,  4'd8, 4'd5, "R4");
      op(ANDI, 4'd8, 4'd6, "R4");
      op(XORI, 4'd8, 4'd9, "R4");
      op(MOVI, 4'd9, 4'd0, "R4");
      idle(3, "R4");
   endtask

   task automatic t_chain;
      // R6: add into r6, then AND that reads r6 on the very next cycle
      op(MOVI, 4'd6, 4'd7, "R6");
      op(ADD, 4'd6, 4'd2, "R6");
      op(AND, 4'd5, 4'd6, "R6");
      op(ADD, 4'd5, 4'd5, "R6");
      op(ADD, 4'd5, 4'd6, "R6");
      idle(3, "R6");
   endtask

   task automatic t_two_ahead;
      // R7: producer, one unrelated slot, then the consumer
      op(ADDI, 4'd10, 4'd11, "R7");
      op(MOVI, 4'd11, 4'd1, "R7");
      op(XOR, 4'd12, 4'd10, "R7");
      op(SUB, 4'd10, 4'd11, "R7");
      idle(1, "R7");
      op(ORR, 4'd13, 4'd10, "R7");
      idle(3, "R7");
   endtask

   task automatic t_same_reg;
      // R8: both operands forwarded, including Rx == Ry
      op(MOVI, 4'd3, 4'd9, "R8");
      op(ADD, 4'd3, 4'd3, "R8");
      op(ADD, 4'd3, 4'd3, "R8");
      op(MOVI, 4'd4, 4'd2, "R8");
      op(SUB, 4'd3, 4'd4, "R8");
      idle(3, "R8");
   endtask

   task automatic t_youngest;
      // R9: two in-flight writers of r2; the younger must win
      op(MOVI, 4'd2, 4'd5, "R9");
      op(MOVI, 4'd2, 4'd9, "R9");
      op(MOV, 4'd14, 4'd2, "R9");
      op(ADD, 4'd2, 4'd1, "R9");
      op(MOVI, 4'd2, 4'd3, "R9");
      op(ADD, 4'd15, 4'd2, "R9");
      idle(3, "R9");
   endtask

   task automatic t_noop;
      // R5: illegal opcodes and empty slots write nothing
      op(MOVI, 4'd1, 4'd4, "R5");
      op(8'h40, 4'd1, 4'd7, "R5");
      op(8'h06, 4'd1, 4'd7, "R5");
      op(8'h0F, 4'd1, 4'd7, "R5");
      step(1'b0, MOVI, 4'd1, 4'd15, "R5");
      op(MOV, 4'd0, 4'd1, "R5");
      idle(3, "R5");
   endtask

   task automatic t_copies;
      // R10: a settled value reads the same through Rx and through Ry
      op(MOVI, 4'd7, 4'd13, "R10");
      idle(4, "R10");
      op(ADDI, 4'd7, 4'd0, "R10");
      op(MOV, 4'd9, 4'd7, "R10");
      idle(4, "R10");
      op(XOR, 4'd9, 4'd7, "R10");
      idle(3, "R10");
   endtask

   task automatic t_wrap;
      // R11: 0 - 1 and all-ones + 1 wrap modulo 2^32
      op(MOVI, 4'd11, 4'd0, "R11");
      op(SUBI, 4'd11, 4'd1, "R11");
      op(MOV, 4'd12, 4'd11, "R11");
      op(ADDI, 4'd12, 4'd1, "R11");
      op(ADD, 4'd11, 4'd11, "R11");
      idle(3, "R11");
   endtask

   task automatic t_dump;
      // R2: final contents of every register against the sequential model
      for (int r = 0; r < 16; r++) op(MOV, 4'(r), 4'(r), "R2");
      idle(3, "R2");
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_alu_ops();
      t_imm();
      t_chain();
      t_two_ahead();
      t_same_reg();
      t_youngest();
      t_noop();
      t_copies();
      t_wrap();
      t_dump();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule